// File: doc/BRIEF.md
# Dual-Enable Bidirectional Latched Transceiver

This block passes data between two ports, A and B, in either direction. Each direction has its own storage bank and three active-low controls: a direction enable, a latch enable and an output enable. The direction enable has two roles. It gates the storage together with the latch enable, and it gates the output driver together with the output enable. The data path is split into byte groups. Each group has its own complete set of controls for both directions.

The ports are kept synthesizable. Each side is shown as a separate input vector, data-out vector and per-bit drive-enable vector, and any tri-state merging happens outside the block. Controls and data are sampled on the rising clock edge. Storage and drive enables are registered, so an output shows the effect of the inputs sampled at the previous edge. Reset is synchronous and active high. It clears all storage and turns every drive enable off.

Top module: `dual_en_xcvr`

## Requirements
- R1: The A-to-B path (a_in to b_out, b_oe) and the B-to-A path (b_in to a_out, a_oe) are controlled only by their own control set. Activity on one path leaves the other path's outputs unchanged.
- R2: If a group's direction enable and latch enable are both sampled low at an edge, that group's destination output equals the source input sampled at that edge, from the next cycle on.
- R3: At the first edge where either the direction enable or the latch enable is sampled high, the output keeps the value captured at the last edge where both were low.
- R4: While either enable is sampled high, changes on the source input do not change the destination output.
- R5: A destination drive-enable bit is 1 after an edge only if that group's output enable and direction enable were both sampled low. Otherwise it is 0.
- R6: Storage loads when direction enable and latch enable are low even while the output enable is high. The loaded value appears when the output enable later goes low with the latch enable high.
- R7: Group g covers bits [8g+7:8g]. Its controls affect only those bits.
- R8: A synchronous reset sets all data outputs to 0 and all drive-enable bits to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | GROUPS*8 | A-side data arriving at the block |
| a_out | output | GROUPS*8 | Data to drive onto A |
| a_oe | output | GROUPS*8 | Per-bit drive enable for A |
| b_in | input | GROUPS*8 | B-side data arriving at the block |
| b_out | output | GROUPS*8 | Data to drive onto B |
| b_oe | output | GROUPS*8 | Per-bit drive enable for B |
| ab_en_n | input | GROUPS | A-to-B direction enable, active low |
| ab_le_n | input | GROUPS | A-to-B latch enable, active low |
| ab_oe_n | input | GROUPS | A-to-B output enable, active low |
| ba_en_n | input | GROUPS | B-to-A direction enable, active low |
| ba_le_n | input | GROUPS | B-to-A latch enable, active low |
| ba_oe_n | input | GROUPS | B-to-A output enable, active low |

## Verification
The control table first runs the transparent state with changing data, which shows that the latch is open rather than loaded once. It then closes the latch separately through the latch enable and through the direction enable, which shows that either enable alone freezes the stored value. Next it loads data with the output disabled and displays it later, which separates storage from driving. Directed cases then give the two groups opposite controls, reset with live transparent data, and drive one direction while the other is idle.

// File: rtl/dual_en_xcvr_pkg.sv
package dual_en_xcvr_pkg;
  localparam int GRP_W = 8;
  typedef struct packed {
    logic en_n;
    logic le_n;
    logic oe_n;
  } dir_ctrl_t;
endpackage

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         en_n,
  input  logic         le_n,
  input  logic         oe_n,
  output logic [W-1:0] dout,
  output logic [W-1:0] drive
);
  logic [W-1:0] store_q;
  logic         oe_q;
  logic         gate_open;

  assign gate_open = ~(en_n | le_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
      oe_q    <= 1'b0;
    end else begin
      if (gate_open) store_q <= din;
      oe_q <= ~(en_n | oe_n);
    end
  end

  assign dout  = store_q;
  assign drive = {W{oe_q}};

  // R2: open gate loads the sampled input
  p_transparent_r2: assert property (@(posedge clk) disable iff (rst)
    (!en_n && !le_n) |=> dout == $past(din));
  // R3 / R4: a closed gate freezes the stored value
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (en_n || le_n) |=> $stable(dout));
  // R5: drive is off unless both enables are low
  p_drive_off_r5: assert property (@(posedge clk) disable iff (rst)
    (en_n || oe_n) |=> drive == '0);
  p_drive_on_r5: assert property (@(posedge clk) disable iff (rst)
    (!en_n && !oe_n) |=> drive == '1);
endmodule

// File: rtl/xcvr_group.sv
module xcvr_group
  import dual_en_xcvr_pkg::*;
#(
  parameter int W = GRP_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  dir_ctrl_t    ab_ctl,
  input  dir_ctrl_t    ba_ctl,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);
  // R1: two independent lanes, one per direction
  xcvr_lane #(.W(W)) u_ab (
    .clk(clk), .rst(rst), .din(a_in),
    .en_n(ab_ctl.en_n), .le_n(ab_ctl.le_n), .oe_n(ab_ctl.oe_n),
    .dout(b_out), .drive(b_oe));

  xcvr_lane #(.W(W)) u_ba (
    .clk(clk), .rst(rst), .din(b_in),
    .en_n(ba_ctl.en_n), .le_n(ba_ctl.le_n), .oe_n(ba_ctl.oe_n),
    .dout(a_out), .drive(a_oe));
endmodule

// File: rtl/dual_en_xcvr.sv
module dual_en_xcvr
  import dual_en_xcvr_pkg::*;
#(
  parameter int GROUPS = 2,
  localparam int DW = GROUPS * GRP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DW-1:0]     a_in,
  output logic [DW-1:0]     a_out,
  output logic [DW-1:0]     a_oe,
  input  logic [DW-1:0]     b_in,
  output logic [DW-1:0]     b_out,
  output logic [DW-1:0]     b_oe,
  input  logic [GROUPS-1:0] ab_en_n,
  input  logic [GROUPS-1:0] ab_le_n,
  input  logic [GROUPS-1:0] ab_oe_n,
  input  logic [GROUPS-1:0] ba_en_n,
  input  logic [GROUPS-1:0] ba_le_n,
  input  logic [GROUPS-1:0] ba_oe_n
);
  // R7: one group per byte, each with its own controls
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    dir_ctrl_t ab_c, ba_c;
    assign ab_c = '{en_n: ab_en_n[g], le_n: ab_le_n[g], oe_n: ab_oe_n[g]};
    assign ba_c = '{en_n: ba_en_n[g], le_n: ba_le_n[g], oe_n: ba_oe_n[g]};

    xcvr_group #(.W(GRP_W)) u_grp (
      .clk(clk), .rst(rst),
      .a_in (a_in [g*GRP_W +: GRP_W]),
      .b_in (b_in [g*GRP_W +: GRP_W]),
      .ab_ctl(ab_c), .ba_ctl(ba_c),
      .a_out(a_out[g*GRP_W +: GRP_W]),
      .a_oe (a_oe [g*GRP_W +: GRP_W]),
      .b_out(b_out[g*GRP_W +: GRP_W]),
      .b_oe (b_oe [g*GRP_W +: GRP_W]));
  end

  // R8: reset leaves nothing driven and nothing stored
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0));
endmodule

// File: tb/tb_dual_en_xcvr.sv
module tb_dual_en_xcvr;
  localparam int G  = 2;
  localparam int DW = G * 8;
  localparam int NSTEP = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] a_in = '0, b_in = '0;
  logic [DW-1:0] a_out, a_oe, b_out, b_oe;
  logic [G-1:0] ab_en_n = '1, ab_le_n = '1, ab_oe_n = '1;
  logic [G-1:0] ba_en_n = '1, ba_le_n = '1, ba_oe_n = '1;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dual_en_xcvr #(.GROUPS(G)) dut (.*);

  // model state
  logic [7:0] m_b [G], m_a [G];
  logic       m_boe [G], m_aoe [G];

  // entry: {ab en,le,oe, ba en,le,oe, a data, b data}
  localparam logic [37:0] TBL [NSTEP] = '{
    {6'b000_000, 16'h1234, 16'hABCD},
    {6'b000_000, 16'h5A5A, 16'h0F0F},
    {6'b010_000, 16'hFFFF, 16'h1111},
    {6'b010_000, 16'h0000, 16'h2222},
    {6'b100_000, 16'h7777, 16'h3333},
    {6'b001_100, 16'h4242, 16'h9999},
    {6'b010_010, 16'h0101, 16'h8888},
    {6'b011_011, 16'hEEEE, 16'hCCCC},
    {6'b111_111, 16'h0001, 16'h0002},
    {6'b000_000, 16'hC3C3, 16'h3C3C}
  };

  task automatic model_edge();
    for (int g = 0; g < G; g++) begin
      if (rst) begin
        m_b[g] = '0; m_a[g] = '0; m_boe[g] = 0; m_aoe[g] = 0;
      end else begin
        if (!ab_en_n[g] && !ab_le_n[g]) m_b[g] = a_in[g*8 +: 8];
        if (!ba_en_n[g] && !ba_le_n[g]) m_a[g] = b_in[g*8 +: 8];
        m_boe[g] = !ab_en_n[g] && !ab_oe_n[g];
        m_aoe[g] = !ba_en_n[g] && !ba_oe_n[g];
      end
    end
  endtask

  task automatic compare(string tag);
    logic [DW-1:0] eb, ea, ebo, eao;
    for (int g = 0; g < G; g++) begin
      eb[g*8 +: 8] = m_b[g]; ea[g*8 +: 8] = m_a[g];
      ebo[g*8 +: 8] = {8{m_boe[g]}}; eao[g*8 +: 8] = {8{m_aoe[g]}};
    end
    checks++;
    if (b_out !== eb || b_oe !== ebo || a_out !== ea || a_oe !== eao) begin
      fails++;
      $display("FAIL %s: b_out=%h b_oe=%h a_out=%h a_oe=%h expected %h %h %h %h",
               tag, b_out, b_oe, a_out, a_oe, eb, ebo, ea, eao);
    end
  endtask

  task automatic cycle(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    @(negedge clk);
    cycle("R8 reset state");
    rst = 1'b0;

    // table walk: R2 transparent, R3 capture, R4 hold, R5 drive, R6 hidden load
    for (int i = 0; i < NSTEP; i++) begin
      {ab_en_n[0], ab_le_n[0], ab_oe_n[0]} = TBL[i][37:35];
      {ba_en_n[0], ba_le_n[0], ba_oe_n[0]} = TBL[i][34:32];
      ab_en_n[1] = ab_en_n[0]; ab_le_n[1] = ab_le_n[0]; ab_oe_n[1] = ab_oe_n[0];
      ba_en_n[1] = ba_en_n[0]; ba_le_n[1] = ba_le_n[0]; ba_oe_n[1] = ba_oe_n[0];
      a_in = TBL[i][31:16];
      b_in = TBL[i][15:0];
      cycle($sformatf("R2/R3 R4 R5 R6 table step %0d", i));
    end

    // R7: group 0 transparent, group 1 held
    ab_en_n = 2'b00; ab_le_n = 2'b10; ab_oe_n = 2'b00;
    a_in = 16'hBEEF;
    cycle("R7 group split load");
    a_in = 16'h1357;
    cycle("R7 group 1 held");

    // R1: A-to-B active, B-to-A idle while b_in moves
    ba_en_n = 2'b11; ba_le_n = 2'b00; ba_oe_n = 2'b00;
    ab_le_n = 2'b00;
    b_in = 16'h6666; a_in = 16'h2468;
    cycle("R1 direction independence");
    b_in = 16'h7171;
    cycle("R1 idle path unchanged");

    // R8: reset while transparent and driving
    rst = 1'b1;
    cycle("R8 mid-run reset");
    rst = 1'b0;
    ab_oe_n = 2'b11;
    a_in = 16'hA5C3;
    cycle("R6 load while disabled");
    ab_le_n = 2'b11; ab_oe_n = 2'b00; a_in = 16'h0000;
    cycle("R6 display stored value");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule